// File: doc/BRIEF.md
# Dual-Bucket Ingress Frame Policer

The policer meters the frames arriving on one switch port. Each frame is announced by a one-cycle start strobe that carries its length in bytes. The block charges the frame against a peak bucket and, when enabled, a committed bucket in front of it. One cycle later it reports a pass or discard verdict.

Both buckets drain on a periodic leak tick by their configured rate. They fill by each admitted frame's cost. A frame is compared with a bucket's limit, which is the configured burst multiplied by the unit of the selected metering mode.

There are four metering modes: line rate, data rate, high frame rate and low frame rate. Internally, frame-rate levels are kept in tenths of a frame, so all four modes share one set of 23-bit bucket arithmetic. A state write port loads either bucket level directly. Writing the maximum level shuts the port off.

Top module: `frame_policer`

## Requirements
- R1: `verdict_valid_o` is high in exactly the cycle after a cycle with `frame_i` high. `verdict_pass_o` and `hit_commit_o` are low whenever `verdict_valid_o` is low.
- R2: A frame's cost is set by `mode_i`. Mode 0 (line rate) costs `len_i + ipg_i` bytes. Mode 1 (data rate) costs `len_i` bytes. Modes 2 and 3 (frame rates) cost 10 units, where one unit is a tenth of a frame.
- R3: A bucket's limit is its burst field multiplied by the mode's unit. Modes 0 and 1 use 4096 bytes. Mode 2 uses 328 units (32.8 frames). Mode 3 uses 3 units (0.3 frame).
- R4: On a cycle with `tick_i` high, each bucket level falls by its leak amount and saturates at 0. The leak amount is the rate field in modes 0, 1 and 3, and the rate field times 100 in mode 2.
- R5: A frame fits a bucket under two conditions. With `overshoot_i` high, the leaked level must be at most the limit. With `overshoot_i` low, the leaked level plus the cost must be at most the limit. The charged bucket's level becomes the leaked level plus the cost, saturating at 2^23-1.
- R6: A discarded frame changes neither bucket level beyond its leak.
- R7: With `cir_en_i` high, the committed bucket is tried first. A fit charges it and sets `hit_commit_o`. Otherwise the peak bucket is tried. With `cir_en_i` low, only the peak bucket decides, and the committed bucket is never charged.
- R8: With `cir_en_i` and `couple_i` both high, the part of a tick's committed leak that exceeds the committed level is also drained from the peak bucket. With `cir_en_i` low, `couple_i` has no effect.
- R9: `state_we_i` loads `state_wdata_i` into the peak bucket (`state_sel_i`=0) or the committed bucket (`state_sel_i`=1). Loading 2^23-1 causes every following frame checked against that bucket to be discarded.
- R10: When a tick and a frame arrive in the same cycle, the leak is applied before the frame is compared and charged.
- R11: After reset both levels are 0 and no verdict is valid.
- R12: A burst field of 0 with `overshoot_i` high admits a frame only when the leaked level is 0. With `overshoot_i` low it admits none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame start strobe |
| len_i | input | 14 | Frame length in bytes |
| tick_i | input | 1 | Leak tick |
| mode_i | input | 2 | Metering mode 0..3 |
| ipg_i | input | 5 | Gap bytes added in mode 0 |
| overshoot_i | input | 1 | Admit while under limit regardless of cost |
| cir_en_i | input | 1 | Enable committed bucket |
| couple_i | input | 1 | Credit spare committed leak to peak |
| pir_i | input | 16 | Peak rate field |
| pbs_i | input | 7 | Peak burst field |
| cir_i | input | 16 | Committed rate field |
| cbs_i | input | 7 | Committed burst field |
| state_we_i | input | 1 | Bucket level write enable |
| state_sel_i | input | 1 | Bucket select for write: 0 peak, 1 committed |
| state_wdata_i | input | 23 | Level to write |
| verdict_valid_o | output | 1 | Verdict strobe |
| verdict_pass_o | output | 1 | Frame admitted |
| hit_commit_o | output | 1 | Frame charged to committed bucket |
| peak_level_o | output | 23 | Peak bucket level |
| commit_level_o | output | 23 | Committed bucket level |

## Verification
Some properties are checked on every cycle:
- the one-cycle verdict timing;
- that a committed hit is always a pass and never occurs with the committed bucket off;
- that a discard or an idle cycle never raises a level.

The exact level arithmetic needs the bench's scenarios. This covers the per-mode cost, limit and leak scaling, overshoot against strict fit, the coupling credit, leak-before-charge ordering, the saturated full state and the zero-burst corner.

// File: rtl/policer_pkg.sv
`timescale 1ns/1ps
package policer_pkg;
  typedef enum logic [1:0] {
    MODE_LINE = 2'd0,
    MODE_DATA = 2'd1,
    MODE_FHI  = 2'd2,
    MODE_FLO  = 2'd3
  } mode_e;

  localparam int FRAME_COST       = 10;   // one frame in tenth-frame units
  localparam int HI_BURST_UNIT    = 328;  // 32.8 frames
  localparam int LO_BURST_UNIT    = 3;    // 0.3 frame
  localparam int BYTE_BURST_SHIFT = 12;   // 4096 bytes
  localparam int HI_RATE_MUL      = 100;  // high/low frame rate unit ratio
endpackage

// File: rtl/policer_scale.sv
`timescale 1ns/1ps
module policer_scale
  import policer_pkg::*;
#(
  parameter int RATE_W  = 16,
  parameter int BURST_W = 7,
  parameter int LVL_W   = 23
) (
  input  mode_e              mode_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic [LVL_W-1:0]   leak_o,
  output logic [LVL_W-1:0]   limit_o
);
  localparam int XW = LVL_W + 1;

  logic [XW-1:0] leak_w, lim_w;

  always_comb begin
    case (mode_i)
      MODE_FHI: begin
        leak_w = XW'(rate_i) * XW'(HI_RATE_MUL);
        lim_w  = XW'(burst_i) * XW'(HI_BURST_UNIT);
      end
      MODE_FLO: begin
        leak_w = XW'(rate_i);
        lim_w  = XW'(burst_i) * XW'(LO_BURST_UNIT);
      end
      default: begin
        leak_w = XW'(rate_i);
        lim_w  = XW'(burst_i) << BYTE_BURST_SHIFT;
      end
    endcase
  end

  assign leak_o  = leak_w[XW-1] ? '1 : leak_w[LVL_W-1:0];
  assign limit_o = lim_w[XW-1]  ? '1 : lim_w[LVL_W-1:0];
endmodule

// File: rtl/policer_cost.sv
`timescale 1ns/1ps
module policer_cost
  import policer_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int IPG_W = 5,
  parameter int LVL_W = 23
) (
  input  mode_e             mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [IPG_W-1:0]  ipg_i,
  output logic [LVL_W-1:0]  cost_o
);
  always_comb begin
    case (mode_i)
      MODE_LINE: cost_o = LVL_W'(len_i) + LVL_W'(ipg_i);
      MODE_DATA: cost_o = LVL_W'(len_i);
      default:   cost_o = LVL_W'(FRAME_COST);
    endcase
  end
endmodule

// File: rtl/policer_bucket.sv
`timescale 1ns/1ps
module policer_bucket #(
  parameter int LVL_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LVL_W-1:0] leak_i,
  input  logic [LVL_W-1:0] credit_i,
  input  logic [LVL_W-1:0] limit_i,
  input  logic [LVL_W-1:0] cost_i,
  input  logic             overshoot_i,
  input  logic             charge_i,
  input  logic             we_i,
  input  logic [LVL_W-1:0] wdata_i,
  output logic [LVL_W-1:0] level_o,
  output logic             fits_o,
  output logic [LVL_W-1:0] spare_o
);
  localparam int XW = LVL_W + 1;

  logic [LVL_W-1:0] level_q, leaked, level_d;
  logic [XW-1:0]    drain, sum;

  // leak (own + coupled credit) applies before any compare
  assign drain  = tick_i ? (XW'(leak_i) + XW'(credit_i)) : '0;
  assign leaked = (XW'(level_q) >= drain) ? LVL_W'(XW'(level_q) - drain) : '0;
  assign spare_o = (tick_i && (leak_i > level_q)) ? (leak_i - level_q) : '0;

  assign sum    = XW'(leaked) + XW'(cost_i);
  assign fits_o = overshoot_i ? (leaked <= limit_i) : (sum <= XW'(limit_i));

  always_comb begin
    if (we_i)          level_d = wdata_i;
    else if (charge_i) level_d = sum[XW-1] ? '1 : sum[LVL_W-1:0];
    else               level_d = leaked;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/frame_policer.sv
`timescale 1ns/1ps
module frame_policer
  import policer_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int IPG_W   = 5,
  parameter int RATE_W  = 16,
  parameter int BURST_W = 7,
  parameter int LVL_W   = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               tick_i,
  input  logic [1:0]         mode_i,
  input  logic [IPG_W-1:0]   ipg_i,
  input  logic               overshoot_i,
  input  logic               cir_en_i,
  input  logic               couple_i,
  input  logic [RATE_W-1:0]  pir_i,
  input  logic [BURST_W-1:0] pbs_i,
  input  logic [RATE_W-1:0]  cir_i,
  input  logic [BURST_W-1:0] cbs_i,
  input  logic               state_we_i,
  input  logic               state_sel_i,
  input  logic [LVL_W-1:0]   state_wdata_i,
  output logic               verdict_valid_o,
  output logic               verdict_pass_o,
  output logic               hit_commit_o,
  output logic [LVL_W-1:0]   peak_level_o,
  output logic [LVL_W-1:0]   commit_level_o
);
  localparam int NB = 2;      // 0: peak, 1: committed
  localparam int PK = 0;
  localparam int CM = 1;

  mode_e mode;
  assign mode = mode_e'(mode_i);

  logic [RATE_W-1:0]  rate  [NB];
  logic [BURST_W-1:0] burst [NB];
  logic [LVL_W-1:0]   leak  [NB];
  logic [LVL_W-1:0]   limit [NB];
  logic [LVL_W-1:0]   credit[NB];
  logic [LVL_W-1:0]   spare [NB];
  logic [LVL_W-1:0]   level [NB];
  logic [NB-1:0]      fits, charge, we;
  logic [LVL_W-1:0]   cost;

  assign rate[PK]  = pir_i;
  assign rate[CM]  = cir_i;
  assign burst[PK] = pbs_i;
  assign burst[CM] = cbs_i;
  assign credit[PK] = (cir_en_i && couple_i) ? spare[CM] : '0;
  assign credit[CM] = '0;

  policer_cost #(.LEN_W(LEN_W), .IPG_W(IPG_W), .LVL_W(LVL_W)) u_cost (
    .mode_i (mode),
    .len_i  (len_i),
    .ipg_i  (ipg_i),
    .cost_o (cost)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    assign we[b] = state_we_i && (state_sel_i == 1'(b));

    policer_scale #(.RATE_W(RATE_W), .BURST_W(BURST_W), .LVL_W(LVL_W)) u_scale (
      .mode_i  (mode),
      .rate_i  (rate[b]),
      .burst_i (burst[b]),
      .leak_o  (leak[b]),
      .limit_o (limit[b])
    );

    policer_bucket #(.LVL_W(LVL_W)) u_bucket (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .leak_i      (leak[b]),
      .credit_i    (credit[b]),
      .limit_i     (limit[b]),
      .cost_i      (cost),
      .overshoot_i (overshoot_i),
      .charge_i    (charge[b]),
      .we_i        (we[b]),
      .wdata_i     (state_wdata_i),
      .level_o     (level[b]),
      .fits_o      (fits[b]),
      .spare_o     (spare[b])
    );
  end

  logic cm_ok, pass;
  assign cm_ok      = cir_en_i && fits[CM];
  assign pass       = cm_ok || fits[PK];
  assign charge[CM] = frame_i && cm_ok;
  assign charge[PK] = frame_i && !cm_ok && fits[PK];

  logic valid_q, pass_q, hit_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= frame_i;
      pass_q  <= frame_i && pass;
      hit_q   <= frame_i && cm_ok;
    end
  end

  assign verdict_valid_o = valid_q;
  assign verdict_pass_o  = pass_q;
  assign hit_commit_o    = hit_q;
  assign peak_level_o    = level[PK];
  assign commit_level_o  = level[CM];
endmodule

// File: rtl/policer_checks.sv
`timescale 1ns/1ps
module policer_checks #(
  parameter int LVL_W = 23
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_i,
  input logic             state_we_i,
  input logic             cir_en_i,
  input logic             verdict_valid_o,
  input logic             verdict_pass_o,
  input logic             hit_commit_o,
  input logic [LVL_W-1:0] peak_level_o,
  input logic [LVL_W-1:0] commit_level_o
);
  assert_verdict_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> verdict_valid_o);

  assert_no_spurious_verdict_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> (!verdict_valid_o && !verdict_pass_o && !hit_commit_o));

  assert_discard_no_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !state_we_i) |=> (verdict_pass_o ||
      (peak_level_o <= $past(peak_level_o) && commit_level_o <= $past(commit_level_o))));

  assert_idle_no_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !state_we_i) |=>
      (peak_level_o <= $past(peak_level_o) && commit_level_o <= $past(commit_level_o)));

  assert_hit_is_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_commit_o |-> (verdict_pass_o && verdict_valid_o));

  assert_single_no_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !cir_en_i) |=> !hit_commit_o);
endmodule

bind frame_policer policer_checks #(.LVL_W(LVL_W)) u_checks (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .frame_i         (frame_i),
  .state_we_i      (state_we_i),
  .cir_en_i        (cir_en_i),
  .verdict_valid_o (verdict_valid_o),
  .verdict_pass_o  (verdict_pass_o),
  .hit_commit_o    (hit_commit_o),
  .peak_level_o    (peak_level_o),
  .commit_level_o  (commit_level_o)
);

// File: tb/test_frame_policer.sv
`timescale 1ns/1ps
module test_frame_policer;
  localparam longint LMAX = (64'd1 << 23) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic [13:0] len_i = '0;
  logic        tick_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [4:0]  ipg_i = 5'd20;
  logic        overshoot_i = 1'b0;
  logic        cir_en_i = 1'b0;
  logic        couple_i = 1'b0;
  logic [15:0] pir_i = '0;
  logic [6:0]  pbs_i = '0;
  logic [15:0] cir_i = '0;
  logic [6:0]  cbs_i = '0;
  logic        state_we_i = 1'b0;
  logic        state_sel_i = 1'b0;
  logic [22:0] state_wdata_i = '0;
  logic        verdict_valid_o, verdict_pass_o, hit_commit_o;
  logic [22:0] peak_level_o, commit_level_o;

  int vectors = 0;
  int fails = 0;
  longint mp = 0, mc = 0;

  always #2.5 clk_i = ~clk_i;

  frame_policer i_frame_policer (.*);

  function automatic longint f_leak(int m, longint r);
    return (m == 2) ? r * 100 : r;
  endfunction
  function automatic longint f_limit(int m, longint b);
    if (m < 2) return b * 4096;
    if (m == 2) return b * 328;
    return b * 3;
  endfunction
  function automatic longint f_cost(int m, longint len, longint ipg);
    if (m == 0) return len + ipg;
    if (m == 1) return len;
    return 10;
  endfunction
  function automatic bit f_fit(bit ov, longint lvl, longint cost, longint lim);
    return ov ? (lvl <= lim) : (lvl + cost <= lim);
  endfunction

  task automatic check(string tag, longint act, longint exp, string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(bit fr, int len, bit tk, bit we, bit sel, longint wd, string tag);
    longint cl, cleak, spare, pl, pleak, cost, nc, np;
    bit c_ok, p_ok, ev, ep, eh;
    @(negedge clk_i);
    frame_i = fr; len_i = 14'(len); tick_i = tk;
    state_we_i = we; state_sel_i = sel; state_wdata_i = 23'(wd);
    cost  = f_cost(mode_i, len, ipg_i);
    cl    = tk ? f_leak(mode_i, cir_i) : 0;
    cleak = (mc > cl) ? mc - cl : 0;
    spare = (tk && cl > mc) ? cl - mc : 0;
    pl    = tk ? f_leak(mode_i, pir_i) + ((cir_en_i && couple_i) ? spare : 0) : 0;
    pleak = (mp > pl) ? mp - pl : 0;
    c_ok  = cir_en_i && f_fit(overshoot_i, cleak, cost, f_limit(mode_i, cbs_i));
    p_ok  = f_fit(overshoot_i, pleak, cost, f_limit(mode_i, pbs_i));
    ev = fr; ep = fr && (c_ok || p_ok); eh = fr && c_ok;
    nc = cleak + ((fr && c_ok) ? cost : 0);
    np = pleak + ((fr && !c_ok && p_ok) ? cost : 0);
    if (nc > LMAX) nc = LMAX;
    if (np > LMAX) np = LMAX;
    if (we && !sel) np = wd;
    if (we && sel)  nc = wd;
    mp = np; mc = nc;
    @(posedge clk_i); #1;
    check({tag, " R1"}, verdict_valid_o, ev, "valid");
    check(tag, verdict_pass_o, ep, "pass");
    check(tag, hit_commit_o, eh, "hit");
    check(tag, peak_level_o, mp, "peak_level");
    check(tag, commit_level_o, mc, "commit_level");
  endtask

  task automatic setup(int m, bit ov, bit ce, bit cp);
    mode_i = 2'(m); overshoot_i = ov; cir_en_i = ce; couple_i = cp; ipg_i = 5'd20;
    case (m)
      0, 1: begin pir_i = 300; pbs_i = 1; cir_i = 200; cbs_i = 1; end
      2:    begin pir_i = 1;   pbs_i = 1; cir_i = 1;   cbs_i = 1; end
      default: begin pir_i = 4; pbs_i = 2; cir_i = 3; cbs_i = 4; end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11", verdict_valid_o, 0, "valid after reset");
    check("R11", peak_level_o, 0, "peak after reset");
    check("R11", commit_level_o, 0, "commit after reset");

    // sweep: every mode, overshoot, committed enable and coupling
    for (int m = 0; m < 4; m++)
      for (int ov = 0; ov < 2; ov++)
        for (int ce = 0; ce < 2; ce++)
          for (int cp = 0; cp < 2; cp++) begin
            string tag;
            tag = $sformatf("R2/R3/R4/R5/R6 %s mode%0d ov%0d",
                            ce ? (cp ? "R8" : "R7") : "R7-off", m, ov);
            setup(m, 1'(ov), 1'(ce), 1'(cp));
            apply(0, 0, 0, 1, 0, 0, "R9");
            apply(0, 0, 0, 1, 1, 0, "R9");
            for (int k = 0; k < 28; k++)
              apply(k % 4 != 3, 64 + (k * 211) % 1400, (k % 3) == 0 || k > 20, 0, 0, 0, tag);
          end

    // saturated peak bucket shuts the port
    setup(1, 1, 0, 0);
    apply(0, 0, 0, 1, 0, LMAX, "R9");
    apply(1, 64, 0, 0, 0, 0, "R9 full");
    apply(1, 64, 1, 0, 0, 0, "R9 full tick");
    setup(3, 1, 1, 0);
    apply(0, 0, 0, 1, 0, LMAX, "R9");
    apply(0, 0, 0, 1, 1, LMAX, "R9");
    apply(1, 64, 0, 0, 0, 0, "R9 both full");

    // zero burst
    setup(1, 1, 0, 0); pbs_i = 0; pir_i = 100;
    apply(0, 0, 0, 1, 0, 0, "R12");
    apply(1, 500, 0, 0, 0, 0, "R12 empty");
    apply(1, 500, 0, 0, 0, 0, "R12 nonempty");
    overshoot_i = 0;
    apply(0, 0, 0, 1, 0, 0, "R12");
    apply(1, 500, 0, 0, 0, 0, "R12 strict");

    // leak before compare in same cycle
    setup(1, 0, 0, 0); pir_i = 1000;
    apply(0, 0, 0, 1, 0, 4000, "R10");
    apply(1, 900, 0, 0, 0, 0, "R10 no tick");
    apply(1, 900, 1, 0, 0, 0, "R10 with tick");

    // coupling credit with empty committed bucket
    setup(0, 0, 1, 1); cir_i = 500; pir_i = 100;
    apply(0, 0, 0, 1, 0, 2000, "R8");
    apply(0, 0, 0, 1, 1, 100, "R8");
    apply(0, 0, 1, 0, 0, 0, "R8 credit");
    couple_i = 0;
    apply(0, 0, 1, 0, 0, 0, "R8 uncoupled");
    cir_en_i = 0; couple_i = 1;
    apply(0, 0, 1, 0, 0, 0, "R8 ignored single");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule